// File: doc/BRIEF.md
# Parallel EPROM read controller

This block lets a synchronous host fetch 16-bit words from an asynchronous one-time-programmable memory of 256K words. The host raises a request together with an 18-bit word address, or with an identification flag, and keeps both steady. The controller drives the memory's address bus and its active-low chip-enable and output-enable strobes. It samples the data bus once the timing has been met, and returns the word with a one-cycle ready pulse.

All waits are counted in clock cycles. Each wait is the ceiling of the required time divided by the clock period, plus one cycle of margin for the capture register. The required times come from a speed-grade parameter: the fast grade needs 120 ns for address or chip-enable to data, 35 ns for output-enable to data and 30 ns for bus float; the slow grade needs 150, 50 and 40 ns. Output enable is not added in series with the address wait. It is asserted only for the last output-enable wait of the access window. Once output enable rises, a float gap must expire before the controller accepts another request. While reads follow each other, chip enable stays low and only the address changes. After a run of idle cycles the controller raises chip enable so that the memory enters standby.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: During and right after reset, mem_ce_no and mem_oe_no are high, rdy_o is low and rdata_o is zero.
- R2: A normal read drives addr_i unchanged on mem_addr_o and returns the memory word at that address on rdata_o.
- R3: Counting the edge that accepts the request as edge 0, the data bus is captured at edge W and rdy_o is high in the cycle that follows. W is the access wait: 16 cycles for the fast grade at 125 MHz, 20 for the slow grade. The address and chip enable stay steady through the whole window.
- R4: Output enable is low for exactly the last OE wait cycles before the capture edge: 6 cycles for the fast grade at 125 MHz, 8 for the slow grade. It is low only while chip enable is low, and the address does not change while it is low.
- R5: rdy_o is high for exactly one cycle, rdata_o then holds the word captured while output enable was still low, and output enable rises on the capture edge.
- R6: Once output enable rises, at least the float wait passes before it falls again: 5 cycles for the fast grade at 125 MHz, 6 for the slow grade. A request raised during this gap is accepted only after it, so its ready arrives float wait + W + 1 edges after the previous ready cycle began.
- R7: Between reads that come less than the idle limit apart, chip enable stays low.
- R8: After the idle limit of cycles with no request, chip enable goes high. The next read then waits the full chip-enable access time and still returns correct data.
- R9: An identification read (id_i high) drives address 0 on every bit except bit 0, which copies addr_i[0]. Bit 0 low selects the manufacturer word and bit 0 high selects the device word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, held until rdy_o |
| id_i | input | 1 | Identification read select, held with req_i |
| addr_i | input | 18 | Word address, held with req_i |
| rdy_o | output | 1 | One-cycle pulse, rdata_o valid |
| rdata_o | output | 16 | Captured read data |
| mem_addr_o | output | 18 | Memory address bus |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_data_i | input | 16 | Memory data bus |

## Verification
The assertions assume the host keeps req_i, id_i and addr_i steady from the cycle it raises the request until it sees rdy_o. They also assume the float and output-enable waits are shorter than the access wait, so the overlap window and the float gap both fit. The bench drives every input on the falling clock edge and holds the request fields until the ready pulse. Its memory model returns valid data only after the raw access and output-enable times have passed on its own cycle counters. A controller that samples early therefore reads a garbage pattern instead of the expected word.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_FLOAT} rd_state_e;

  // ceil(t / period) plus one cycle for the capture register
  function automatic int wait_cycles(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps + 1;
  endfunction
endpackage

// File: rtl/eprom_wait_cnt.sv
module eprom_wait_cnt #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eprom_idle_timer.sv
module eprom_idle_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q == LIM);
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int CLK_PS     = 8000,
  parameter bit SLOW_GRADE = 1'b0,
  parameter int IDLE_LIMIT = 8,
  parameter int AW         = 18,
  parameter int DW         = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          id_i,
  input  logic [AW-1:0] addr_i,
  output logic          rdy_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  input  logic [DW-1:0] mem_data_i
);
  localparam int T_ACC_PS = SLOW_GRADE ? 150000 : 120000;
  localparam int T_CE_PS  = T_ACC_PS;
  localparam int T_OE_PS  = SLOW_GRADE ? 50000 : 35000;
  localparam int T_DF_PS  = SLOW_GRADE ? 40000 : 30000;
  localparam int ACC_W = wait_cycles(T_ACC_PS, CLK_PS);
  localparam int CE_W  = wait_cycles(T_CE_PS, CLK_PS);
  localparam int OE_W  = wait_cycles(T_OE_PS, CLK_PS);
  localparam int DF_W  = wait_cycles(T_DF_PS, CLK_PS);
  localparam int MAX_W = (ACC_W > CE_W) ? ACC_W : CE_W;
  localparam int CW    = $clog2(MAX_W + 1);
  localparam logic [CW-1:0] ACC_LD = CW'(ACC_W - 1);
  localparam logic [CW-1:0] CE_LD  = CW'(CE_W - 1);
  localparam logic [CW-1:0] OE_AT  = CW'(OE_W);
  localparam logic [CW-1:0] DF_LD  = CW'(DF_W - 1);

  rd_state_e     st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata_q;
  logic          ce_n_q, oe_n_q, rdy_q;
  logic          accept, capture, idle_exp;
  logic [CW-1:0] acc_cnt, flt_cnt;
  logic          acc_zero, flt_zero;

  assign accept  = (st_q == ST_IDLE) && req_i;
  assign capture = (st_q == ST_ACCESS) && acc_zero;

  // access window: full CE time from standby, address time otherwise
  eprom_wait_cnt #(.CW(CW)) u_acc_cnt (
    .clk_i, .rst_ni,
    .load_i     (accept),
    .load_val_i (ce_n_q ? CE_LD : ACC_LD),
    .dec_i      (st_q == ST_ACCESS),
    .cnt_o      (acc_cnt),
    .zero_o     (acc_zero)
  );

  eprom_wait_cnt #(.CW(CW)) u_flt_cnt (
    .clk_i, .rst_ni,
    .load_i     (capture),
    .load_val_i (DF_LD),
    .dec_i      (st_q == ST_FLOAT),
    .cnt_o      (flt_cnt),
    .zero_o     (flt_zero)
  );

  eprom_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk_i, .rst_ni,
    .run_i    ((st_q == ST_IDLE) && !ce_n_q && !req_i),
    .expire_o (idle_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rdata_q <= '0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            st_q   <= ST_ACCESS;
            addr_q <= id_i ? {{(AW-1){1'b0}}, addr_i[0]} : addr_i;
            ce_n_q <= 1'b0;
          end else if (idle_exp) begin
            ce_n_q <= 1'b1;
          end
        end
        ST_ACCESS: begin
          if (acc_zero) begin
            rdata_q <= mem_data_i;
            rdy_q   <= 1'b1;
            oe_n_q  <= 1'b1;
            st_q    <= ST_FLOAT;
          end else if (acc_cnt == OE_AT) begin
            oe_n_q  <= 1'b0;  // late OE, overlapped with address wait
          end
        end
        ST_FLOAT: begin
          if (flt_zero) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_ce_no  = ce_n_q;
  assign mem_oe_no  = oe_n_q;
  assign rdy_o      = rdy_q;
  assign rdata_o    = rdata_q;

  // cycles since OE last rose, saturating at the float wait
  localparam int GW = $clog2(DF_W + 1);
  localparam logic [GW-1:0] GMAX = GW'(DF_W);
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gap_q <= GMAX;
    else if (!oe_n_q)   gap_q <= '0;
    else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
  end

  a_r4_oe_inside_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_ce_no);
  a_r4_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no && $past(!mem_oe_no)) |-> $stable(mem_addr_o));
  a_r5_rdy_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);
  a_r5_captured_while_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (mem_oe_no && $past(!mem_oe_no)));
  a_r6_float_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_no) |-> (gap_q >= GMAX));
  a_r8_standby_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> (mem_oe_no && !rdy_o));
endmodule

// File: tb/tb_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_eprom_rd_ctrl;
  localparam int CLK_PS = 8000;
  localparam int IDLE_LIMIT = 8;
  // expected counts, derived from the fast-grade times at 125 MHz
  localparam int RAW_ACC = (120000 + CLK_PS - 1) / CLK_PS;
  localparam int RAW_OE  = (35000 + CLK_PS - 1) / CLK_PS;
  localparam int ACC_W = RAW_ACC + 1;
  localparam int OE_W  = RAW_OE + 1;
  localparam int DF_W  = (30000 + CLK_PS - 1) / CLK_PS + 1;
  localparam logic [15:0] MFR_WORD = 16'h001F;
  localparam logic [15:0] DEV_WORD = 16'hF4A3;
  localparam logic [15:0] JUNK     = 16'hF0F0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, id = 1'b0;
  logic [17:0] addr = '0;
  logic rdy, ce_n, oe_n;
  logic [15:0] rdata, mdata;
  logic [17:0] maddr;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  eprom_rd_ctrl #(.CLK_PS(CLK_PS), .SLOW_GRADE(1'b0), .IDLE_LIMIT(IDLE_LIMIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .id_i(id), .addr_i(addr),
    .rdy_o(rdy), .rdata_o(rdata), .mem_addr_o(maddr),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_data_i(mdata)
  );

  function automatic logic [15:0] word_at(input logic [17:0] a);
    if (a == 18'd0) return MFR_WORD;
    if (a == 18'd1) return DEV_WORD;
    return a[15:0] ^ {a[17:16], 14'h02A5};
  endfunction

  // memory model: ages counted on falling edges
  logic [17:0] last_a = '0;
  int a_age = 0, ce_age = 0, oe_age = 0;
  always @(negedge clk) begin
    a_age  <= (maddr != last_a) ? 1 : (a_age < 1000 ? a_age + 1 : a_age);
    last_a <= maddr;
    ce_age <= ce_n ? 0 : (ce_age < 1000 ? ce_age + 1 : ce_age);
    oe_age <= oe_n ? 0 : (oe_age < 1000 ? oe_age + 1 : oe_age);
  end
  assign mdata = (!ce_n && !oe_n && a_age >= RAW_ACC && ce_age >= RAW_ACC
                  && oe_age >= RAW_OE) ? word_at(maddr) : JUNK;

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop, strobe shape checks
  int oe_low = 0, oe_high = 100;
  logic oe_prev = 1'b1;
  logic [17:0] a_prev = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy) begin
        if (exp_q.size() == 0) check("R5 unexpected ready", 1, 0);
        else check("R2 read data", {16'h0, rdata}, {16'h0, exp_q.pop_front()});
      end
      if (!oe_n && ce_n) check("R4 oe without ce", 1, 0);
      if (!oe_n && !oe_prev && maddr != a_prev) check("R4 address moved under oe", 1, 0);
      if (oe_n && !oe_prev) check("R4 oe low window", oe_low, OE_W);
      if (!oe_n && oe_prev && oe_high < DF_W) check("R6 float gap", oe_high, DF_W);
      oe_low  <= oe_n ? 0 : oe_low + 1;
      oe_high <= oe_n ? (oe_high < 100 ? oe_high + 1 : oe_high) : 0;
      oe_prev <= oe_n;
      a_prev  <= maddr;
    end
  end

  // driver: called on a falling edge, returns on the falling edge showing ready
  task automatic rd(input logic [17:0] a, input logic is_id, input int exp_lat, input string tag);
    int lat;
    req  = 1'b1;
    id   = is_id;
    addr = a;
    exp_q.push_back(word_at(is_id ? {17'd0, a[0]} : a));
    lat = 0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (rdy) break;
    end
    check(tag, lat, exp_lat);
  endtask

  task automatic idle_for(input int n);
    req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ce_n in reset", ce_n, 1);
    check("R1 oe_n in reset", oe_n, 1);
    check("R1 rdy in reset", rdy, 0);
    check("R1 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ce_n after reset", ce_n, 1);

    rd(18'h00005, 1'b0, ACC_W + 1, "R8 latency from standby");
    idle_for(1);
    check("R2 address on bus", maddr, 18'h00005);
    idle_for(DF_W + 1);
    check("R7 ce held low", ce_n, 0);
    rd(18'h2ABCD, 1'b0, ACC_W + 1, "R3 latency with ce low");
    idle_for(DF_W + 2);
    rd(18'h1F00F, 1'b0, ACC_W + 1, "R3 latency second");
    rd(18'h3FFFE, 1'b0, DF_W + 1 + ACC_W, "R6 request during float");
    check("R7 ce low across chained reads", ce_n, 0);
    idle_for(IDLE_LIMIT + DF_W + 6);
    check("R8 standby after idle", ce_n, 1);
    check("R8 oe high in standby", oe_n, 1);
    rd(18'h3FFFF, 1'b1, ACC_W + 1, "R9 id device latency");
    idle_for(1);
    check("R9 id address bit0 high", maddr, 18'd1);
    idle_for(DF_W + 1);
    rd(18'h12340, 1'b1, ACC_W + 1, "R9 id manufacturer latency");
    idle_for(1);
    check("R9 id address bit0 low", maddr, 18'd0);
    idle_for(DF_W + 1);
    rd(18'h0FFFF, 1'b0, ACC_W + 1, "R2 latency plain");
    rd(18'h20000, 1'b0, DF_W + 1 + ACC_W, "R6 chained again");
    idle_for(DF_W + 4);
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule